// File: doc/BRIEF.md
# Sectored Cache Hit Classifier

This block holds the tag and validity state of a direct-mapped cache whose 128-byte lines are split into four aligned 32-byte sectors. Validity is tracked per sector, not per line. A lookup gives an address and a 4-bit mask of the sectors wanted from that line.

The lookup returns two kinds of result. One is a tag result: either the line is installed with a matching tag, or it is not. The other is a per-sector hit/miss split. A sector whose tag matches but whose data is absent is still a miss. Four saturating counters total tag hits, tag misses, sector hits and sector misses.

A fill port installs or extends a line. An invalidate input drops every line. The data array, the replacement policy beyond direct mapping, the write policy and the next memory level all sit outside this block.

Top module: `sector_cache_classifier`

## Requirements
- R1: Address bits [6:0] (byte offset in [4:0], sector number in [6:5]) have no effect on which line a lookup or fill touches. Bits [6+INDEX_BITS:7] select the set, and the upper ADDR_W-7-INDEX_BITS bits are the tag.
- R2: A lookup presented with lookup_valid_i high gives res_valid_o high on the next clock edge, with the result attached. In a cycle with no lookup, the next edge drives res_valid_o, res_tag_hit_o and both sector vectors to zero.
- R3: res_tag_hit_o is 1 only when the selected set holds an installed line whose tag equals the lookup tag. After reset or invalidate, no line is installed.
- R4: Sector k (mask bit k) is reported as a hit in res_sector_hit_o[k] only when the tag hits, bit k of the mask is set and sector k is valid. Every other requested sector is reported in res_sector_miss_o[k]. Unrequested sectors appear in neither vector. On a tag miss, every requested sector is a miss.
- R5: A fill whose tag differs from the installed tag of its set, or that targets an empty set, installs the new tag. The set's sector valid bits become exactly the fill mask.
- R6: A fill whose tag matches the installed tag ORs the fill mask into the existing sector valid bits.
- R7: inval_i clears every line on the next edge. It takes priority over a fill in the same cycle.
- R8: A lookup in the same cycle as a fill or invalidate is classified against the state from before that cycle's update.
- R9: Each accepted lookup adds one to either tag_hit_cnt_o or tag_miss_cnt_o, on the same edge that registers its result.
- R10: Each accepted lookup adds the number of its sector hits to sec_hit_cnt_o and the number of its sector misses to sec_miss_cnt_o.
- R11: All counters saturate at all-ones and never wrap.
- R12: cnt_clr_i zeroes all four counters on the next edge. It overrides any increment in the same cycle and leaves the tag and valid state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_addr_i | input | ADDR_W | Lookup byte address |
| lookup_mask_i | input | 4 | Sectors wanted, bit k = sector k |
| fill_valid_i | input | 1 | Fill request |
| fill_addr_i | input | ADDR_W | Fill byte address |
| fill_mask_i | input | 4 | Sectors made valid by the fill |
| inval_i | input | 1 | Invalidate all lines |
| cnt_clr_i | input | 1 | Synchronous counter clear |
| res_valid_o | output | 1 | Registered result valid |
| res_tag_hit_o | output | 1 | Tag hit of the registered lookup |
| res_sector_hit_o | output | 4 | Requested sectors that hit |
| res_sector_miss_o | output | 4 | Requested sectors that missed |
| tag_hit_cnt_o | output | CNT_W | Tag hit count |
| tag_miss_cnt_o | output | CNT_W | Tag miss count |
| sec_hit_cnt_o | output | CNT_W | Sector hit count |
| sec_miss_cnt_o | output | CNT_W | Sector miss count |

## Verification
The assertions assume that lookup_valid_i is low while reset is asserted. They also treat a lookup mask as meaningful only in the cycle it is presented. The properties on monotonic and saturating counters hold for any input sequence.

The stimulus draws tags from a small pool and sets from a narrow index field, so that same-tag refills, conflicting refills and tag-hit-data-miss cases occur often. The stimulus raises invalidate and counter clear only rarely. Narrow counters in the bench make saturation reachable.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned SECTORS  = 4;
  localparam int unsigned LINE_LSB = 7;  // 128-byte line
  localparam int unsigned INC_W    = 3;  // up to 4 per lookup
  typedef logic [SECTORS-1:0] sec_mask_t;

  function automatic logic [INC_W-1:0] pop4(input sec_mask_t m);
    pop4 = INC_W'(m[0]) + INC_W'(m[1]) + INC_W'(m[2]) + INC_W'(m[3]);
  endfunction
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store import sc_pkg::*; #(
  parameter int unsigned INDEX_BITS = 4,
  parameter int unsigned TAG_W      = 21,
  localparam int unsigned SETS      = 1 << INDEX_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [INDEX_BITS-1:0] rd_idx_i,
  output logic [TAG_W-1:0]      rd_tag_o,
  output logic                  rd_line_v_o,
  output sec_mask_t             rd_sec_v_o,
  input  logic                  fill_en_i,
  input  logic [INDEX_BITS-1:0] fill_idx_i,
  input  logic [TAG_W-1:0]      fill_tag_i,
  input  sec_mask_t             fill_mask_i,
  input  logic                  inval_i
);
  logic [TAG_W-1:0] tag_q  [SETS];
  logic             line_q [SETS];
  sec_mask_t        sec_q  [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel, same;
    assign sel  = fill_en_i && (fill_idx_i == INDEX_BITS'(s));
    assign same = line_q[s] && (tag_q[s] == fill_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q[s] <= 1'b0;
        sec_q[s]  <= '0;
      end else if (inval_i) begin
        line_q[s] <= 1'b0;
        sec_q[s]  <= '0;
      end else if (sel) begin
        line_q[s] <= 1'b1;
        sec_q[s]  <= same ? (sec_q[s] | fill_mask_i) : fill_mask_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel && !inval_i && !same) tag_q[s] <= fill_tag_i;
    end
  end

  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_line_v_o = line_q[rd_idx_i];
  assign rd_sec_v_o  = sec_q[rd_idx_i];
endmodule

// File: rtl/sc_classify.sv
module sc_classify import sc_pkg::*; #(
  parameter int unsigned TAG_W = 21
) (
  input  logic [TAG_W-1:0] lk_tag_i,
  input  sec_mask_t        lk_mask_i,
  input  logic [TAG_W-1:0] st_tag_i,
  input  logic             st_line_v_i,
  input  sec_mask_t        st_sec_v_i,
  output logic             tag_hit_o,
  output sec_mask_t        sec_hit_o,
  output sec_mask_t        sec_miss_o
);
  always_comb begin
    tag_hit_o  = st_line_v_i && (st_tag_i == lk_tag_i);
    sec_hit_o  = tag_hit_o ? (lk_mask_i & st_sec_v_i) : '0;
    sec_miss_o = lk_mask_i & ~sec_hit_o;
  end
endmodule

// File: rtl/sc_sat_counter.sv
module sc_sat_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0] MAX = {1'b0, {CNT_W{1'b1}}};
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (clr_i)     cnt_o <= '0;
    else if (sum > MAX) cnt_o <= '1;
    else                cnt_o <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/sector_cache_classifier.sv
module sector_cache_classifier import sc_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INDEX_BITS = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned TAG_W     = ADDR_W - LINE_LSB - INDEX_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic [3:0]        lookup_mask_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [3:0]        fill_mask_i,
  input  logic              inval_i,
  input  logic              cnt_clr_i,
  output logic              res_valid_o,
  output logic              res_tag_hit_o,
  output logic [3:0]        res_sector_hit_o,
  output logic [3:0]        res_sector_miss_o,
  output logic [CNT_W-1:0]  tag_hit_cnt_o,
  output logic [CNT_W-1:0]  tag_miss_cnt_o,
  output logic [CNT_W-1:0]  sec_hit_cnt_o,
  output logic [CNT_W-1:0]  sec_miss_cnt_o
);
  logic unused_offset;
  assign unused_offset = ^{lookup_addr_i[LINE_LSB-1:0], fill_addr_i[LINE_LSB-1:0]};

  logic [INDEX_BITS-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0]      lk_tag, fl_tag, st_tag;
  logic                  st_line_v, tag_hit;
  sec_mask_t             st_sec_v, sec_hit, sec_miss;

  assign lk_idx = lookup_addr_i[LINE_LSB +: INDEX_BITS];
  assign fl_idx = fill_addr_i[LINE_LSB +: INDEX_BITS];
  assign lk_tag = lookup_addr_i[ADDR_W-1 -: TAG_W];
  assign fl_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

  sc_tag_store #(.INDEX_BITS(INDEX_BITS), .TAG_W(TAG_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_idx), .rd_tag_o(st_tag), .rd_line_v_o(st_line_v), .rd_sec_v_o(st_sec_v),
    .fill_en_i(fill_valid_i), .fill_idx_i(fl_idx), .fill_tag_i(fl_tag),
    .fill_mask_i(fill_mask_i), .inval_i(inval_i)
  );

  sc_classify #(.TAG_W(TAG_W)) u_cls (
    .lk_tag_i(lk_tag), .lk_mask_i(lookup_mask_i),
    .st_tag_i(st_tag), .st_line_v_i(st_line_v), .st_sec_v_i(st_sec_v),
    .tag_hit_o(tag_hit), .sec_hit_o(sec_hit), .sec_miss_o(sec_miss)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o       <= 1'b0;
      res_tag_hit_o     <= 1'b0;
      res_sector_hit_o  <= '0;
      res_sector_miss_o <= '0;
    end else begin
      res_valid_o       <= lookup_valid_i;
      res_tag_hit_o     <= lookup_valid_i && tag_hit;
      res_sector_hit_o  <= lookup_valid_i ? sec_hit  : '0;
      res_sector_miss_o <= lookup_valid_i ? sec_miss : '0;
    end
  end

  // counter order: tag hit, tag miss, sector hit, sector miss
  logic [INC_W-1:0] inc [4];
  logic [CNT_W-1:0] cnt [4];

  always_comb begin
    inc[0] = INC_W'(lookup_valid_i &&  tag_hit);
    inc[1] = INC_W'(lookup_valid_i && !tag_hit);
    inc[2] = lookup_valid_i ? pop4(sec_hit)  : '0;
    inc[3] = lookup_valid_i ? pop4(sec_miss) : '0;
  end

  for (genvar c = 0; c < 4; c++) begin : g_cnt
    sc_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i(cnt_clr_i), .inc_i(inc[c]), .cnt_o(cnt[c])
    );
  end

  assign tag_hit_cnt_o  = cnt[0];
  assign tag_miss_cnt_o = cnt[1];
  assign sec_hit_cnt_o  = cnt[2];
  assign sec_miss_cnt_o = cnt[3];
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_valid_i,
  input logic [3:0]        lookup_mask_i,
  input logic              cnt_clr_i,
  input logic              res_valid_o,
  input logic              res_tag_hit_o,
  input logic [3:0]        res_sector_hit_o,
  input logic [3:0]        res_sector_miss_o,
  input logic [CNT_W-1:0]  tag_hit_cnt_o,
  input logic [CNT_W-1:0]  tag_miss_cnt_o,
  input logic [CNT_W-1:0]  sec_hit_cnt_o,
  input logic [CNT_W-1:0]  sec_miss_cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  assert_res_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(lookup_valid_i));

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_tag_hit_o && res_sector_hit_o == 4'd0 && res_sector_miss_o == 4'd0));

  assert_disjoint_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_sector_hit_o & res_sector_miss_o) == 4'd0);

  assert_mask_cover_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ((res_sector_hit_o | res_sector_miss_o) == $past(lookup_mask_i)));

  assert_tag_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_tag_hit_o) |-> res_sector_hit_o == 4'd0);

  assert_no_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cnt_clr_i) |-> (tag_hit_cnt_o >= $past(tag_hit_cnt_o) &&
                           tag_miss_cnt_o >= $past(tag_miss_cnt_o)));

  assert_sat_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_clr_i) && $past(sec_miss_cnt_o) == MAX) |-> sec_miss_cnt_o == MAX);

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_clr_i) |-> (tag_hit_cnt_o == '0 && tag_miss_cnt_o == '0 &&
                          sec_hit_cnt_o == '0 && sec_miss_cnt_o == '0));
endmodule

bind sector_cache_classifier sc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lookup_valid_i(lookup_valid_i),
  .lookup_mask_i(lookup_mask_i), .cnt_clr_i(cnt_clr_i),
  .res_valid_o(res_valid_o), .res_tag_hit_o(res_tag_hit_o),
  .res_sector_hit_o(res_sector_hit_o), .res_sector_miss_o(res_sector_miss_o),
  .tag_hit_cnt_o(tag_hit_cnt_o), .tag_miss_cnt_o(tag_miss_cnt_o),
  .sec_hit_cnt_o(sec_hit_cnt_o), .sec_miss_cnt_o(sec_miss_cnt_o)
);

// File: tb/sector_cache_classifier_tb.sv
`timescale 1ns/1ps
module sector_cache_classifier_tb;
  localparam int unsigned AW = 16, IB = 3, CW = 8;
  localparam int unsigned TW = AW - 7 - IB;
  localparam int unsigned NS = 1 << IB;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk_i = 0, rst_ni = 0;
  logic lookup_valid_i = 0, fill_valid_i = 0, inval_i = 0, cnt_clr_i = 0;
  logic [AW-1:0] lookup_addr_i = '0, fill_addr_i = '0;
  logic [3:0] lookup_mask_i = '0, fill_mask_i = '0;
  logic res_valid_o, res_tag_hit_o;
  logic [3:0] res_sector_hit_o, res_sector_miss_o;
  logic [CW-1:0] tag_hit_cnt_o, tag_miss_cnt_o, sec_hit_cnt_o, sec_miss_cnt_o;

  always #2 clk_i = ~clk_i;

  sector_cache_classifier #(.ADDR_W(AW), .INDEX_BITS(IB), .CNT_W(CW)) u_dut (.*);

  int checks = 0, fails = 0;
  logic [TW-1:0] m_tag [NS];
  logic          m_line [NS];
  logic [3:0]    m_vld [NS];
  logic [CW-1:0] m_cnt [4];
  logic          e_valid, e_thit;
  logic [3:0]    e_hit, e_miss;

  function automatic logic [AW-1:0] mk_addr(int tag, int set, int low);
    return {TW'(tag), IB'(set), 7'(low)};
  endfunction

  function automatic logic [CW-1:0] sat_add(logic [CW-1:0] c, int n);
    return (int'(c) + n > int'(CMAX)) ? CMAX : CW'(int'(c) + n);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  // one cycle: drive, predict from pre-update state, update model, check after edge
  task automatic cyc(logic lv, logic [AW-1:0] la, logic [3:0] lm,
                     logic fv, logic [AW-1:0] fa, logic [3:0] fm,
                     logic inv, logic clr, string rq);
    int s, fs;
    @(negedge clk_i);
    lookup_valid_i = lv; lookup_addr_i = la; lookup_mask_i = lm;
    fill_valid_i = fv; fill_addr_i = fa; fill_mask_i = fm;
    inval_i = inv; cnt_clr_i = clr;
    s = int'(la[7 +: IB]);
    e_valid = lv;
    e_thit  = lv && m_line[s] && (m_tag[s] == la[AW-1 -: TW]);
    e_hit   = e_thit ? (lm & m_vld[s]) : 4'd0;
    e_miss  = lv ? (lm & ~e_hit) : 4'd0;
    if (clr) for (int c = 0; c < 4; c++) m_cnt[c] = '0;
    else if (lv) begin
      m_cnt[0] = sat_add(m_cnt[0], int'(e_thit));
      m_cnt[1] = sat_add(m_cnt[1], int'(!e_thit));
      m_cnt[2] = sat_add(m_cnt[2], $countones(e_hit));
      m_cnt[3] = sat_add(m_cnt[3], $countones(e_miss));
    end
    if (inv) begin
      for (int i = 0; i < NS; i++) begin m_line[i] = 0; m_vld[i] = '0; end
    end else if (fv) begin
      fs = int'(fa[7 +: IB]);
      if (m_line[fs] && m_tag[fs] == fa[AW-1 -: TW]) m_vld[fs] = m_vld[fs] | fm;
      else begin m_tag[fs] = fa[AW-1 -: TW]; m_line[fs] = 1; m_vld[fs] = fm; end
    end
    @(posedge clk_i); #1;
    chk({rq, " res_valid R2"}, 32'(res_valid_o), 32'(e_valid));
    chk({rq, " tag_hit R3"}, 32'(res_tag_hit_o), 32'(e_thit));
    chk({rq, " sec_hit R4"}, 32'(res_sector_hit_o), 32'(e_hit));
    chk({rq, " sec_miss R4"}, 32'(res_sector_miss_o), 32'(e_miss));
    chk({rq, (m_cnt[0] == CMAX) ? " tag_hit_cnt R11" : " tag_hit_cnt R9"}, 32'(tag_hit_cnt_o), 32'(m_cnt[0]));
    chk({rq, (m_cnt[1] == CMAX) ? " tag_miss_cnt R11" : " tag_miss_cnt R9"}, 32'(tag_miss_cnt_o), 32'(m_cnt[1]));
    chk({rq, (m_cnt[2] == CMAX) ? " sec_hit_cnt R11" : " sec_hit_cnt R10"}, 32'(sec_hit_cnt_o), 32'(m_cnt[2]));
    chk({rq, (m_cnt[3] == CMAX) ? " sec_miss_cnt R11" : " sec_miss_cnt R10"}, 32'(sec_miss_cnt_o), 32'(m_cnt[3]));
  endtask

  task automatic look(logic [AW-1:0] a, logic [3:0] m, string rq);
    cyc(1, a, m, 0, '0, 4'd0, 0, 0, rq);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NS; i++) begin m_line[i] = 0; m_vld[i] = '0; m_tag[i] = '0; end
    for (int c = 0; c < 4; c++) m_cnt[c] = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("reset res_valid R2", 32'(res_valid_o), 0);
    chk("reset counter R12", 32'(tag_hit_cnt_o | sec_miss_cnt_o), 0);
    rst_ni = 1;

    look(mk_addr(5, 2, 0), 4'b1111, "R3 empty");
    cyc(1, mk_addr(5, 2, 0), 4'b0011, 1, mk_addr(5, 2, 0), 4'b0011, 0, 0, "R8 same-cycle fill");
    look(mk_addr(5, 2, 0), 4'b1111, "R4 partial");
    cyc(0, '0, 4'd0, 1, mk_addr(5, 2, 33), 4'b0100, 0, 0, "R6 or-fill");
    look(mk_addr(5, 2, 0), 4'b1111, "R6 after or");
    look(mk_addr(5, 2, 7'h7f), 4'b0101, "R1 offset bits");
    look(mk_addr(5, 3, 0), 4'b0001, "R1 other set");
    cyc(0, '0, 4'd0, 1, mk_addr(9, 2, 0), 4'b1000, 0, 0, "R5 new tag");
    look(mk_addr(5, 2, 0), 4'b1111, "R5 old tag");
    look(mk_addr(9, 2, 0), 4'b1111, "R5 new tag");
    look(mk_addr(9, 2, 0), 4'b0000, "R4 empty mask");
    cyc(1, mk_addr(9, 2, 0), 4'b1000, 1, mk_addr(9, 2, 0), 4'b1111, 1, 0, "R7 inval+fill");
    look(mk_addr(9, 2, 0), 4'b1111, "R7 after inval");
    cyc(1, mk_addr(9, 2, 0), 4'b1111, 0, '0, 4'd0, 0, 1, "R12 clear+lookup");
    cyc(0, '0, 4'd0, 0, '0, 4'd0, 0, 0, "R2 idle");

    for (int n = 0; n < 3000; n++) begin
      cyc($urandom_range(0, 3) != 0, mk_addr($urandom_range(0, 3), $urandom_range(0, NS-1), $urandom_range(0, 127)),
          4'($urandom_range(0, 15)),
          $urandom_range(0, 2) == 0, mk_addr($urandom_range(0, 3), $urandom_range(0, NS-1), $urandom_range(0, 127)),
          4'($urandom_range(0, 15)),
          $urandom_range(0, 199) == 0, (n > 2000) && ($urandom_range(0, 299) == 0), "rand");
    end
    for (int n = 0; n < 300; n++) look(mk_addr(0, n % NS, 0), 4'b1111, "R11 push");
    chk("R11 miss saturated", 32'(sec_miss_cnt_o), 32'(CMAX));
    cyc(0, '0, 4'd0, 0, '0, 4'd0, 0, 1, "R12 final clear");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule